// File: doc/BRIEF.md
# Temperature-Indexed DAC Code Generator

This block turns the most recent die-temperature reading into a 10-bit setting for a delta-sigma DAC. Each new reading becomes an address into a 72-entry main table, with one entry for every 2 °C. A coarser band selector picks one of eight offset entries. The main entry fills the upper eight bits of the code, and the offset entry, scaled by four, is added to it. The sum is clamped at full scale. The tables live outside the block and are read through two synchronous read ports, each with one cycle of latency.

After reset the block keeps its output undriven for a programmable settling interval. When that interval ends, it starts driving a start-up code supplied from nonvolatile storage. Firmware can switch off automatic control and set the code by hand. While automatic control is off, firmware can also point the table index at any entry. A transmit-disable control, armed by its own enable bit, forces the code to zero without losing the value underneath.

Top module: `dac_tcode_gen`

## Requirements
- R1: From reset until the INIT_CYCLES-th clock edge after reset release, dac_drive_o is 0 and dac_code_o is 0. On edge INIT_CYCLES+1, dac_drive_o becomes 1, and it stays 1 until the next reset. On that same edge dac_code_o takes init_code_i.
- R2: Temperature is signed 16-bit with 8 fraction bits, so the whole degrees T are the arithmetic value of temp_i shifted right by 8. On the edge that accepts a strobe, lut_addr_o becomes 0 for T < -40, 71 for T >= 104, and otherwise floor((T+40)/2).
- R3: On the same edge, off_addr_o becomes the band number 0..7. Band k starts at the k-th of these limits: -8, 8, 24, 40, 56, 70, 88 °C. Every T below -8 falls in band 0.
- R4: In automatic mode, a strobe accepted on edge E0 makes dac_code_o equal 4*main_data_i + 4*off_data_i after edge E0+3. The table data is the value read at the addresses from R2 and R3.
- R5: temp_vld_i is ignored while auto_en_i is 0 and before the R1 interval ends. In those cases neither lut_addr_o nor dac_code_o changes.
- R6: While auto_en_i is 0, dac_code_o shows the manual register two edges after a man_wr_i write. While auto_en_i is 1, man_wr_i is ignored. The manual register starts at init_code_i.
- R7: While auto_en_i is 0, idx_wr_i loads lut_addr_o on the next edge, and values above 71 are clamped to 71. While auto_en_i is 1, idx_wr_i is ignored.
- R8: While txd_i and txd_rst_en_i are both 1, dac_code_o is 0 one edge later and dac_drive_o stays 1. txd_i alone has no effect. After release, the code returns to the value its mode selects one edge later.
- R9: When 4*main + 4*off exceeds 1023, the code saturates at 1023. A sum of exactly 1020 passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | 16 | Signed temperature, 8 fraction bits |
| temp_vld_i | input | 1 | New temperature strobe |
| lut_addr_o | output | 7 | Main table read address |
| main_data_i | input | 8 | Main table read data, one cycle after address |
| off_addr_o | output | 3 | Offset table read address (band) |
| off_data_i | input | 8 | Offset table read data, one cycle after address |
| auto_en_i | input | 1 | Automatic control enable |
| man_wr_i | input | 1 | Manual code write strobe |
| man_val_i | input | 10 | Manual code value |
| idx_wr_i | input | 1 | Table index write strobe |
| idx_val_i | input | 7 | Table index value |
| txd_i | input | 1 | Software transmit-disable |
| txd_rst_en_i | input | 1 | Lets transmit-disable reset the code |
| init_code_i | input | 10 | Start-up code from nonvolatile storage |
| dac_code_o | output | 10 | DAC code |
| dac_drive_o | output | 1 | Output drive enable |

## Verification
A table update in automatic mode can finish in the same cycle that transmit-disable is holding the output at zero. The bench starts a strobe while the armed disable is asserted, then confirms the code stays 0 through the whole three-edge pipeline. After it releases the disable, it expects the freshly computed table value one edge later rather than the stale one. Manual writes made during automatic mode are checked the same way, by switching modes afterwards and reading the code that appears.

// File: rtl/dacgen_pkg.sv
package dacgen_pkg;
  localparam int TEMP_W_DEF  = 16;
  localparam int FRAC_W_DEF  = 8;
  localparam int CODE_W_DEF  = 10;
  localparam int ENTRY_W_DEF = 8;
  localparam int DEPTH_DEF   = 72;
  localparam int BANDS_DEF   = 8;
  localparam int T_LOW_DEF   = -40;

  // lower limit in whole degrees of band k
  function automatic int band_floor(input int k);
    case (k)
      0:       band_floor = -40;
      1:       band_floor = -8;
      2:       band_floor = 8;
      3:       band_floor = 24;
      4:       band_floor = 40;
      5:       band_floor = 56;
      6:       band_floor = 70;
      7:       band_floor = 88;
      default: band_floor = 104;
    endcase
  endfunction
endpackage

// File: rtl/tdac_init_timer.sv
module tdac_init_timer #(
  parameter int INIT_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  output logic ready_o,
  output logic fire_o
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  assign fire_o  = !ready_q && (cnt_q == CNT_W'(INIT_CYCLES - 1));
  assign ready_o = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (fire_o) ready_q <= 1'b1;
    end
  end

  // R1: once the settling interval ends it never restarts without reset
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);
endmodule

// File: rtl/tdac_indexer.sv
module tdac_indexer
  import dacgen_pkg::*;
#(
  parameter int TEMP_W  = 16,
  parameter int FRAC_W  = 8,
  parameter int DEPTH   = 72,
  parameter int BANDS   = 8,
  parameter int T_LOW   = -40,
  parameter int STEP_SH = 1,
  parameter int IDX_W   = $clog2(DEPTH),
  parameter int BAND_W  = $clog2(BANDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BAND_W-1:0] band_o
);
  int                whole;
  int                rel;
  logic [BANDS-2:0]  above;
  logic [IDX_W-1:0]  idx_n;
  logic [IDX_W-1:0]  wr_clamped;
  logic [BAND_W-1:0] band_n;
  logic [IDX_W-1:0]  idx_q;
  logic [BAND_W-1:0] band_q;

  assign whole = int'($signed(temp_i)) >>> FRAC_W;
  assign rel   = whole - T_LOW;

  // one comparator per band limit above the lowest
  for (genvar gk = 0; gk < BANDS - 1; gk++) begin : g_edge
    assign above[gk] = (whole >= band_floor(gk + 1));
  end

  always_comb begin
    if (rel < 0)                        idx_n = '0;
    else if ((rel >>> STEP_SH) >= DEPTH) idx_n = IDX_W'(DEPTH - 1);
    else                                idx_n = IDX_W'(rel >>> STEP_SH);
    band_n = BAND_W'($countones(above));
    wr_clamped = (int'(wr_idx_i) >= DEPTH) ? IDX_W'(DEPTH - 1) : wr_idx_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      band_q <= '0;
    end else if (load_i) begin
      idx_q  <= idx_n;
      band_q <= band_n;
    end else if (wr_i) begin
      idx_q  <= wr_clamped;
    end
  end

  assign idx_o  = idx_q;
  assign band_o = band_q;

  // R2/R7: the address never leaves the table
  a_r2_idx_in_table: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < DEPTH);
  // R7: with neither a strobe nor a write, the address holds
  a_r7_idx_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !wr_i) |=> $stable(idx_q));
endmodule

// File: rtl/tdac_combiner.sv
module tdac_combiner #(
  parameter int ENTRY_W = 8,
  parameter int CODE_W  = 10,
  parameter int OFF_SH  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_i,
  input  logic [CODE_W-1:0]  init_code_i,
  input  logic               vld_i,
  input  logic [ENTRY_W-1:0] main_i,
  input  logic [ENTRY_W-1:0] off_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int MAIN_SH = CODE_W - ENTRY_W;
  localparam int SUM_W   = CODE_W + 2;
  localparam int MAX     = (1 << CODE_W) - 1;

  logic [SUM_W-1:0]  sum;
  logic [CODE_W-1:0] sat;
  logic [CODE_W-1:0] code_q;

  assign sum = (SUM_W'(main_i) << MAIN_SH) + (SUM_W'(off_i) << OFF_SH);
  assign sat = (sum > SUM_W'(MAX)) ? CODE_W'(MAX) : sum[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (init_i) code_q <= init_code_i;
    else if (vld_i)  code_q <= sat;
  end

  assign code_o = code_q;

  // R4: the table value changes only on a completed lookup or start-up load
  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!vld_i && !init_i) |=> $stable(code_q));
  // R9: table entries summing past full scale give all ones
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !init_i && ((int'(main_i) + int'(off_i)) >= (1 << ENTRY_W)))
      |=> (code_q == CODE_W'(MAX)));
endmodule

// File: rtl/dac_tcode_gen.sv
module dac_tcode_gen
  import dacgen_pkg::*;
#(
  parameter int TEMP_W      = TEMP_W_DEF,
  parameter int FRAC_W      = FRAC_W_DEF,
  parameter int CODE_W      = CODE_W_DEF,
  parameter int ENTRY_W     = ENTRY_W_DEF,
  parameter int MAIN_DEPTH  = DEPTH_DEF,
  parameter int OFF_BANDS   = BANDS_DEF,
  parameter int INIT_CYCLES = 500,
  parameter int IDX_W       = $clog2(MAIN_DEPTH),
  parameter int BAND_W      = $clog2(OFF_BANDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic               temp_vld_i,
  output logic [IDX_W-1:0]   lut_addr_o,
  input  logic [ENTRY_W-1:0] main_data_i,
  output logic [BAND_W-1:0]  off_addr_o,
  input  logic [ENTRY_W-1:0] off_data_i,
  input  logic               auto_en_i,
  input  logic               man_wr_i,
  input  logic [CODE_W-1:0]  man_val_i,
  input  logic               idx_wr_i,
  input  logic [IDX_W-1:0]   idx_val_i,
  input  logic               txd_i,
  input  logic               txd_rst_en_i,
  input  logic [CODE_W-1:0]  init_code_i,
  output logic [CODE_W-1:0]  dac_code_o,
  output logic               dac_drive_o
);
  logic              ready;
  logic              fire;
  logic              accept;
  logic              v1_q;
  logic              v2_q;
  logic [CODE_W-1:0] table_code;
  logic [CODE_W-1:0] man_q;
  logic [CODE_W-1:0] out_q;
  logic              drive_q;
  logic              txd_force;

  assign accept    = temp_vld_i && auto_en_i && ready;
  assign txd_force = txd_i && txd_rst_en_i;

  tdac_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .ready_o(ready), .fire_o(fire)
  );

  tdac_indexer #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .DEPTH(MAIN_DEPTH), .BANDS(OFF_BANDS),
    .T_LOW(T_LOW_DEF), .STEP_SH(1), .IDX_W(IDX_W), .BAND_W(BAND_W)
  ) u_index (
    .clk(clk), .rst(rst), .load_i(accept), .temp_i(temp_i),
    .wr_i(idx_wr_i && !auto_en_i), .wr_idx_i(idx_val_i),
    .idx_o(lut_addr_o), .band_o(off_addr_o)
  );

  // v1: address presented, v2: storage data present
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= accept;
      v2_q <= v1_q;
    end
  end

  tdac_combiner #(.ENTRY_W(ENTRY_W), .CODE_W(CODE_W), .OFF_SH(2)) u_comb (
    .clk(clk), .rst(rst), .init_i(fire), .init_code_i(init_code_i),
    .vld_i(v2_q), .main_i(main_data_i), .off_i(off_data_i), .code_o(table_code)
  );

  always_ff @(posedge clk) begin
    if (rst)                        man_q <= '0;
    else if (fire)                  man_q <= init_code_i;
    else if (man_wr_i && !auto_en_i) man_q <= man_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= ready;
      if (!ready || txd_force) out_q <= '0;
      else if (auto_en_i)      out_q <= table_code;
      else                     out_q <= man_q;
    end
  end

  assign dac_code_o  = out_q;
  assign dac_drive_o = drive_q;

  // R1: nothing but zero while the output is undriven
  a_r1_quiet_undriven: assert property (@(posedge clk) disable iff (rst)
    !dac_drive_o |-> (dac_code_o == '0));
  // R1: drive stays on once enabled
  a_r1_drive_sticky: assert property (@(posedge clk) disable iff (rst)
    dac_drive_o |=> dac_drive_o);
  // R7: in automatic mode the address moves only on a strobe
  a_r7_index_locked: assert property (@(posedge clk) disable iff (rst)
    (auto_en_i && !temp_vld_i) |=> $stable(lut_addr_o));
  // R8: armed transmit-disable zeroes the code on the next edge
  a_r8_txd_zero: assert property (@(posedge clk) disable iff (rst)
    txd_force |=> (dac_code_o == '0));
endmodule

// File: tb/sim_dac_tcode_gen.sv
`timescale 1ns/1ps
module sim_dac_tcode_gen;
  localparam int INIT  = 16;
  localparam int DEPTH = 72;
  localparam int ICODE = 333;
  localparam int NV    = 22;
  localparam int TV [NV] = '{-128, -41, -40, -39, -9, -8, -1, 7, 8, 23, 24,
                             39, 40, 55, 56, 69, 70, 87, 88, 103, 104, 127};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] temp = '0;
  logic        tvld = 1'b0;
  logic [6:0]  lut_addr;
  logic [7:0]  main_rd;
  logic [2:0]  off_addr;
  logic [7:0]  off_rd;
  logic        auto_en = 1'b1;
  logic        man_wr = 1'b0;
  logic [9:0]  man_val = '0;
  logic        idx_wr = 1'b0;
  logic [6:0]  idx_val = '0;
  logic        txd = 1'b0;
  logic        txd_en = 1'b0;
  logic [9:0]  code;
  logic        drive;
  logic [7:0]  main_mem [DEPTH];
  logic [7:0]  off_mem [8];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    main_rd <= main_mem[lut_addr];
    off_rd  <= off_mem[off_addr];
  end

  dac_tcode_gen #(.INIT_CYCLES(INIT)) u0 (
    .clk(clk), .rst(rst), .temp_i(temp), .temp_vld_i(tvld),
    .lut_addr_o(lut_addr), .main_data_i(main_rd), .off_addr_o(off_addr),
    .off_data_i(off_rd), .auto_en_i(auto_en), .man_wr_i(man_wr),
    .man_val_i(man_val), .idx_wr_i(idx_wr), .idx_val_i(idx_val),
    .txd_i(txd), .txd_rst_en_i(txd_en), .init_code_i(10'(ICODE)),
    .dac_code_o(code), .dac_drive_o(drive)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int t);
    if (t < -40) return 0;
    if ((t + 40) / 2 > DEPTH - 1) return DEPTH - 1;
    return (t + 40) / 2;
  endfunction

  function automatic int exp_band(input int t);
    int b = 0;
    if (t >= -8) b = 1;
    if (t >= 8)  b = 2;
    if (t >= 24) b = 3;
    if (t >= 40) b = 4;
    if (t >= 56) b = 5;
    if (t >= 70) b = 6;
    if (t >= 88) b = 7;
    return b;
  endfunction

  function automatic int exp_code(input int t);
    int s = 4 * int'(main_mem[exp_idx(t)]) + 4 * int'(off_mem[exp_band(t)]);
    return (s > 1023) ? 1023 : s;
  endfunction

  // strobe on one edge; address checked after it, code after edge +3
  task automatic apply_temp(input int t, input int frac, input bit chk_code);
    int ec = exp_code(t);
    @(negedge clk);
    temp = 16'(t * 256 + frac);
    tvld = 1'b1;
    @(negedge clk);
    tvld = 1'b0;
    check("R2 index", int'(lut_addr), exp_idx(t));
    check("R3 band", int'(off_addr), exp_band(t));
    repeat (3) @(negedge clk);
    if (chk_code) check("R4 code", int'(code), ec);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) main_mem[i] = 8'(2 * i);
    for (int b = 0; b < 8; b++) off_mem[b] = 8'(16 * b);

    repeat (3) @(negedge clk);
    check("R1 reset drive", int'(drive), 0);
    check("R1 reset code", int'(code), 0);
    rst = 1'b0;

    // settling interval, with a strobe that must be ignored (R5)
    for (int k = 1; k <= INIT; k++) begin
      @(negedge clk);
      if (k == 3) begin temp = 16'(50 * 256); tvld = 1'b1; end
      if (k == 4) tvld = 1'b0;
    end
    check("R1 undriven at end of interval", int'(drive), 0);
    check("R1 code zero while undriven", int'(code), 0);
    @(negedge clk);
    check("R1 drive rises", int'(drive), 1);
    check("R1 start-up code", int'(code), ICODE);
    check("R5 early strobe ignored addr", int'(lut_addr), 0);

    // table walk across every band limit
    for (int i = 0; i < NV; i++) apply_temp(TV[i], (i * 37) & 255, 1'b1);

    // R9 saturation and exact 1020
    off_mem[7] = 8'd255;
    apply_temp(100, 0, 1'b0);
    check("R9 saturate", int'(code), 1023);
    off_mem[0] = 8'd255;
    apply_temp(-50, 0, 1'b0);
    check("R9 exact 1020", int'(code), 1020);

    // R6 manual write ignored in automatic mode
    @(negedge clk); man_val = 10'd300; man_wr = 1'b1;
    @(negedge clk); man_wr = 1'b0; auto_en = 1'b0;
    @(negedge clk);
    check("R6 auto-mode write ignored", int'(code), ICODE);
    man_wr = 1'b1;
    @(negedge clk); man_wr = 1'b0;
    @(negedge clk);
    check("R6 manual code", int'(code), 300);

    // R5 strobe ignored in manual mode
    begin
      int a0 = int'(lut_addr);
      @(negedge clk); temp = 16'(10 * 256); tvld = 1'b1;
      @(negedge clk); tvld = 1'b0;
      repeat (3) @(negedge clk);
      check("R5 manual strobe addr", int'(lut_addr), a0);
      check("R5 manual strobe code", int'(code), 300);
    end

    // R7 index writes
    idx_val = 7'd5; idx_wr = 1'b1;
    @(negedge clk); idx_wr = 1'b0;
    check("R7 index write", int'(lut_addr), 5);
    idx_val = 7'd100; idx_wr = 1'b1;
    @(negedge clk); idx_wr = 1'b0;
    check("R7 index clamp", int'(lut_addr), 71);
    idx_val = 7'd5; idx_wr = 1'b1;
    @(negedge clk); idx_wr = 1'b0; auto_en = 1'b1;
    idx_val = 7'd9; idx_wr = 1'b1;
    @(negedge clk); idx_wr = 1'b0;
    @(negedge clk);
    check("R7 auto-mode index write ignored", int'(lut_addr), 5);
    check("R6 auto returns table code", int'(code), 1020);

    // R8 transmit-disable
    txd = 1'b1; txd_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 unarmed no effect", int'(code), 1020);
    txd_en = 1'b1;
    @(negedge clk);
    check("R8 forced zero", int'(code), 0);
    check("R8 drive kept", int'(drive), 1);
    apply_temp(30, 64, 1'b0);
    check("R8 zero through update", int'(code), 0);
    txd = 1'b0;
    @(negedge clk);
    check("R8 release shows new code", int'(code), 472);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule